// File: doc/BRIEF.md
# Register File Port Steering and A-Operand Bypass Control

This block steers the two 4-bit address buses of a 16-entry, two-read-port register file in a three-stage 16-bit pipeline with fetch, decode and execute stages. Each pipeline cycle has two halves. In the read half, the buses carry the register numbers that the decode-stage instruction reads. In the write half, both buses carry the destination number of the execute-stage instruction, so that its result can be written back before the next cycle.

The halves come from a phase register that toggles on every edge of `clk_i`. The clock is never used as data. One pipeline cycle is therefore two clocks: a read half followed by a write half. The block also decides two things for the write half. The first is whether the execute-stage result is forwarded into the A operand in place of the stale register file value. The second is whether the register file write is enabled.

Only the A operand has a bypass path. A hazard on the B operand is left to instruction scheduling. The storage, the ALU and the operand multiplexers are outside this block.

Top module: `rf_port_ctrl`

## Requirements
- R1: The phase alternates on every clock edge. The first clock after reset release is a read half. In a read half, `port_a_o` and `port_b_o` carry the decode-stage sources. In a write half, both carry the execute-stage destination.
- R2: The A source is r0 when `dc_call_i` is 1. Otherwise it is `dc_rd_i` when `dc_two_op_i` is 1, and `dc_ra_i` in every other case.
- R3: The B source is `dc_rd_i` when `dc_store_i` is 1, and `dc_rb_i` otherwise.
- R4: The execute-stage destination is r15 when `ex_call_i` is 1, and `ex_rd_i` otherwise.
- R5: During the write half, `fwd_a_o` is 1 exactly when the destination equals the A source, the execute instruction is not annulled, and the destination is not r0. All inputs are those held through the preceding read half.
- R6: A destination that equals only the B source never raises `fwd_a_o`.
- R7: During the write half, `rf_we_o` is 1 exactly when all of these hold in the preceding read half: `pipe_en_i` is 1, `ex_has_result_i` is 1, `ex_annul_i` is 0, and the destination is not r0. `ex_has_result_i` is 0 for the immediate prefix, branches and stores.
- R8: While reset is asserted, `fwd_a_o` and `rf_we_o` are 0 and the ports carry the read-half sources.
- R9: `fwd_a_o` and `rf_we_o` are 0 in every read half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle clock; two edges make one pipeline cycle |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pipe_en_i | input | 1 | Pipeline advance enable for the current pipeline cycle |
| dc_rd_i | input | 4 | Decode-stage destination field |
| dc_ra_i | input | 4 | Decode-stage first source field |
| dc_rb_i | input | 4 | Decode-stage second source field |
| dc_two_op_i | input | 1 | Decode format where the destination field is also the A source |
| dc_call_i | input | 1 | Decode-stage call; A source is implicitly r0 |
| dc_store_i | input | 1 | Decode-stage store; B port reads the data register in `dc_rd_i` |
| ex_rd_i | input | 4 | Execute-stage destination field |
| ex_call_i | input | 1 | Execute-stage call; destination is implicitly r15 |
| ex_annul_i | input | 1 | Execute-stage instruction is annulled |
| ex_has_result_i | input | 1 | Execute-stage instruction writes a register |
| port_a_o | output | 4 | Register file port A number |
| port_b_o | output | 4 | Register file port B number |
| fwd_a_o | output | 1 | Select the result bus for the A operand |
| rf_we_o | output | 1 | Register file write enable |

## Verification
The assertions assume that the decode and execute inputs and `pipe_en_i` stay stable from the start of a read half through the end of the following write half. This is how a surrounding pipeline changes them once per pipeline cycle. They also assume that `dc_two_op_i` and `dc_store_i` are never 1 together.

The stimulus finds the phase by watching the ports, then changes inputs only just after the edge that opens a read half. It sweeps formats, equal and unequal register numbers on both ports, annul, r0 and implicit r15 destinations, pipeline enable and the result flag. It holds each set for a full read and write half.

// File: rtl/rf_port_ctrl_pkg.sv
package rf_port_ctrl_pkg;
  localparam int unsigned RIDX_W   = 4;
  localparam int unsigned NUM_REGS = 1 << RIDX_W;
  localparam logic [RIDX_W-1:0] ZERO_REG = '0;
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NUM_REGS - 1);

  typedef logic [RIDX_W-1:0] ridx_t;

  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } phase_e;
endpackage

// File: rtl/rfpc_src_sel.sv
module rfpc_src_sel
  import rf_port_ctrl_pkg::*;
(
  input  ridx_t dc_rd_i,
  input  ridx_t dc_ra_i,
  input  ridx_t dc_rb_i,
  input  logic  dc_two_op_i,
  input  logic  dc_call_i,
  input  logic  dc_store_i,
  output ridx_t src_a_o,
  output ridx_t src_b_o
);
  // A source: an implicit r0 for a call takes priority over the format select.
  always_comb begin
    if (dc_call_i)        src_a_o = ZERO_REG;
    else if (dc_two_op_i) src_a_o = dc_rd_i;
    else                  src_a_o = dc_ra_i;
  end

  // B source: a store reads its data register through the destination field.
  always_comb begin
    src_b_o = dc_store_i ? dc_rd_i : dc_rb_i;
  end
endmodule

// File: rtl/rfpc_dst_sel.sv
module rfpc_dst_sel
  import rf_port_ctrl_pkg::*;
(
  input  ridx_t ex_rd_i,
  input  logic  ex_call_i,
  input  logic  ex_annul_i,
  input  logic  ex_has_result_i,
  output ridx_t ex_dst_o,
  output logic  dst_live_o,
  output logic  wr_ok_o
);
  logic dst_nonzero;

  always_comb begin
    ex_dst_o    = ex_call_i ? LINK_REG : ex_rd_i;
    dst_nonzero = (ex_dst_o != ZERO_REG);
    // A live destination may feed the bypass; a write also needs a real result.
    dst_live_o  = dst_nonzero && !ex_annul_i;
    wr_ok_o     = dst_live_o && ex_has_result_i;
  end
endmodule

// File: rtl/rfpc_bypass.sv
module rfpc_bypass
  import rf_port_ctrl_pkg::*;
(
  input  ridx_t src_a_i,
  input  ridx_t ex_dst_i,
  input  logic  dst_live_i,
  output logic  hit_o
);
  logic [RIDX_W-1:0] bit_eq;

  // Per-bit equality, reduced in one AND tree.
  for (genvar g = 0; g < RIDX_W; g++) begin : g_eq
    assign bit_eq[g] = ~(src_a_i[g] ^ ex_dst_i[g]);
  end

  assign hit_o = dst_live_i && (&bit_eq);
endmodule

// File: rtl/rf_port_ctrl.sv
module rf_port_ctrl
  import rf_port_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       pipe_en_i,
  input  logic [3:0] dc_rd_i,
  input  logic [3:0] dc_ra_i,
  input  logic [3:0] dc_rb_i,
  input  logic       dc_two_op_i,
  input  logic       dc_call_i,
  input  logic       dc_store_i,
  input  logic [3:0] ex_rd_i,
  input  logic       ex_call_i,
  input  logic       ex_annul_i,
  input  logic       ex_has_result_i,
  output logic [3:0] port_a_o,
  output logic [3:0] port_b_o,
  output logic       fwd_a_o,
  output logic       rf_we_o
);
  // Reset: asserted asynchronously, released through a synchronizer chain.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // Decode and execute field selection.
  ridx_t src_a, src_b, ex_dst;
  logic  dst_live, wr_ok, hit;

  rfpc_src_sel i_src_sel (
    .dc_rd_i     (dc_rd_i),
    .dc_ra_i     (dc_ra_i),
    .dc_rb_i     (dc_rb_i),
    .dc_two_op_i (dc_two_op_i),
    .dc_call_i   (dc_call_i),
    .dc_store_i  (dc_store_i),
    .src_a_o     (src_a),
    .src_b_o     (src_b)
  );

  rfpc_dst_sel i_dst_sel (
    .ex_rd_i         (ex_rd_i),
    .ex_call_i       (ex_call_i),
    .ex_annul_i      (ex_annul_i),
    .ex_has_result_i (ex_has_result_i),
    .ex_dst_o        (ex_dst),
    .dst_live_o      (dst_live),
    .wr_ok_o         (wr_ok)
  );

  rfpc_bypass i_bypass (
    .src_a_i    (src_a),
    .ex_dst_i   (ex_dst),
    .dst_live_i (dst_live),
    .hit_o      (hit)
  );

  // Phase and write-half controls: next state.
  phase_e phase_q, phase_d;
  logic   fwd_q, fwd_d;
  logic   we_q, we_d;
  logic   ctl_en;

  always_comb begin
    phase_d = (phase_q == PH_READ) ? PH_WRITE : PH_READ;
    ctl_en  = 1'b1;
    if (phase_q == PH_READ) begin
      fwd_d = hit;
      we_d  = pipe_en_i && wr_ok;
    end else begin
      fwd_d = 1'b0;
      we_d  = 1'b0;
    end
  end

  // Phase and write-half controls: registers.
  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_READ;
      fwd_q   <= 1'b0;
      we_q    <= 1'b0;
    end else if (ctl_en) begin
      phase_q <= phase_d;
      fwd_q   <= fwd_d;
      we_q    <= we_d;
    end
  end

  // Port steering: sources in the read half, destination in the write half.
  always_comb begin
    if (phase_q == PH_WRITE) begin
      port_a_o = ex_dst;
      port_b_o = ex_dst;
    end else begin
      port_a_o = src_a;
      port_b_o = src_b;
    end
  end

  assign fwd_a_o = fwd_q;
  assign rf_we_o = we_q;

  // Both ports address the same register while writing back (R1).
  p_ports_agree_r1: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (phase_q == PH_WRITE) |-> (port_a_o == port_b_o));

  // Forward never follows an annulled or r0 destination (R5).
  p_fwd_qualified_r5: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    fwd_a_o |-> (!$past(ex_annul_i) && ($past(ex_call_i) || ($past(ex_rd_i) != ZERO_REG))));

  // Write needs the pipeline enable and a real result (R7).
  p_we_qualified_r7: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    rf_we_o |-> ($past(pipe_en_i) && $past(ex_has_result_i) && !$past(ex_annul_i)));

  // Neither control is active in a read half (R9).
  p_ctl_write_half_r9: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (fwd_a_o || rf_we_o) |-> (phase_q == PH_WRITE));

  // Decode formats that pick the A and B sources never overlap.
  p_fmt_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $onehot0({dc_two_op_i, dc_store_i}));
endmodule

// File: tb/test_rf_port_ctrl.sv
`timescale 1ns/1ps
module test_rf_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pipe_en;
  logic [3:0] dc_rd, dc_ra, dc_rb, ex_rd;
  logic       dc_two_op, dc_call, dc_store;
  logic       ex_call, ex_annul, ex_has_result;
  logic [3:0] port_a, port_b;
  logic       fwd_a, rf_we;

  always #2 clk = ~clk;

  rf_port_ctrl i_rf_port_ctrl (
    .clk_i           (clk),
    .rst_n_i         (rst_n),
    .pipe_en_i       (pipe_en),
    .dc_rd_i         (dc_rd),
    .dc_ra_i         (dc_ra),
    .dc_rb_i         (dc_rb),
    .dc_two_op_i     (dc_two_op),
    .dc_call_i       (dc_call),
    .dc_store_i      (dc_store),
    .ex_rd_i         (ex_rd),
    .ex_call_i       (ex_call),
    .ex_annul_i      (ex_annul),
    .ex_has_result_i (ex_has_result),
    .port_a_o        (port_a),
    .port_b_o        (port_b),
    .fwd_a_o         (fwd_a),
    .rf_we_o         (rf_we)
  );

  typedef struct {
    logic [3:0] pa;
    logic [3:0] pb;
    logic [3:0] dst;
    logic       fwd;
    logic       we;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one input set and push the result that the requirements predict.
  task automatic drive(input int fmt, input logic [3:0] d, input logic [3:0] erd,
                       input bit ecall, input bit eq_a, input bit eq_b,
                       input bit ann, input bit pen, input bit hres);
    exp_t       e;
    logic [3:0] ta, tb, oa, ob, sa, sb, dst;
    ta = eq_a ? d : (d ^ 4'h3);
    tb = eq_b ? d : (d ^ 4'h5);
    oa = d ^ 4'h9;
    ob = d ^ 4'h6;
    dc_call = (fmt == 0); dc_two_op = (fmt == 1); dc_store = (fmt == 2);
    case (fmt)
      1:       begin dc_rd = ta; dc_ra = oa; dc_rb = tb; end
      2:       begin dc_rd = tb; dc_ra = ta; dc_rb = ob; end
      default: begin dc_rd = oa; dc_ra = ta; dc_rb = tb; end
    endcase
    ex_rd = erd; ex_call = ecall; ex_annul = ann;
    pipe_en = pen; ex_has_result = hres;
    // Reference model from R2, R3 and R4.
    sa  = dc_call ? 4'd0 : (dc_two_op ? dc_rd : dc_ra);
    sb  = dc_store ? dc_rd : dc_rb;
    dst = ecall ? 4'd15 : erd;
    e.pa  = sa;
    e.pb  = sb;
    e.dst = dst;
    e.fwd = (dst == sa) && !ann && (dst != 4'd0);
    e.we  = pen && hres && !ann && (dst != 4'd0);
    exp_q.push_back(e);
  endtask

  // Monitor: read half first, then write half, then pop.
  initial begin
    bit half = 0;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        if (!half) begin
          check(port_a == exp_q[0].pa, "R2", port_a, exp_q[0].pa);
          check(port_b == exp_q[0].pb, "R3", port_b, exp_q[0].pb);
          check(!fwd_a && !rf_we, "R9", {fwd_a, rf_we}, 0);
        end else begin
          check(port_a == exp_q[0].dst, "R4", port_a, exp_q[0].dst);
          check(port_b == exp_q[0].dst, "R1", port_b, exp_q[0].dst);
          check(fwd_a == exp_q[0].fwd, "R5/R6 fwd", fwd_a, exp_q[0].fwd);
          check(rf_we == exp_q[0].we, "R7", rf_we, exp_q[0].we);
          void'(exp_q.pop_front());
        end
        half = !half;
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int k = 0;
    rst_n = 1'b0;
    pipe_en = 1'b1; ex_has_result = 1'b1; ex_annul = 1'b0; ex_call = 1'b0;
    dc_two_op = 1'b0; dc_call = 1'b0; dc_store = 1'b0;
    dc_ra = 4'd1; dc_rb = 4'd3; dc_rd = 4'd4; ex_rd = 4'd1;
    repeat (3) @(negedge clk);
    // R8: controls cleared and ports in the read half while reset is held.
    check(!fwd_a, "R8 fwd", fwd_a, 0);
    check(!rf_we, "R8 we", rf_we, 0);
    check(port_a == 4'd1 && port_b == 4'd3, "R8 ports", {port_a, port_b}, {4'd1, 4'd3});
    ex_rd = 4'd2;
    rst_n = 1'b1;
    // Locate the phase at the ports: a write half shows the destination.
    do @(negedge clk); while (port_a != 4'd2);
    check(port_b == 4'd2, "R1 align", port_b, 2);
    @(posedge clk);
    #1;
    for (int fmt = 0; fmt < 4; fmt++)
      for (int dm = 0; dm < 3; dm++)
        for (int ea = 0; ea < 2; ea++)
          for (int eb = 0; eb < 2; eb++)
            for (int an = 0; an < 2; an++)
              for (int pe = 0; pe < 2; pe++)
                for (int hr = 0; hr < 2; hr++) begin
                  logic [3:0] d, erd;
                  k++;
                  // dm 0: ordinary destination, 1: r0, 2: implicit r15 via call.
                  d   = (dm == 1) ? 4'd0 : ((dm == 2) ? 4'd15 : 4'(1 + (k % 14)));
                  erd = (dm == 2) ? 4'(2 + (k % 5)) : d;
                  drive(fmt, d, erd, dm == 2, ea[0], eb[0], an[0], pe[0], hr[0]);
                  @(posedge clk);
                  @(posedge clk);
                  #1;
                end
    wait (exp_q.size() == 0);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule